// File: doc/BRIEF.md
# PCM Transmit Serial Port

This block puts 8-bit companded voice samples onto a time-division multiplexed highway. An upstream encoder hands over one parallel word per frame with a load strobe. The port holds that word until the next frame boundary and then shifts it out serially, most significant bit first, on rising edges of the selected bit clock. It drives a data output together with an output-enable, so that a tri-state pad outside the block can release the highway outside the timeslot.

Two timing modes are supported. In fixed-rate mode the master clock is the bit clock. A frame-sync pulse one bit period wide marks a normal frame. A pulse two bit periods wide marks a signalling frame, in which the eighth bit carries the signalling input instead of the word's LSB when mu-law is selected. In this mode an active-low timeslot strobe gates an external line buffer. In variable-rate mode a separate data clock shifts the bits. The word is sent again in every following timeslot for as long as frame sync stays high.

All inputs are synchronous to a fast fabric clock. Each bit clock is seen as a level, and the port acts on its rising transitions.

Top module: `pcm_tx_port`

## Requirements
- R1: After reset, dout_oe_o is 0 and ts_n_o is 1.
- R2: A frame starts at the first rising bit-clock transition on which fsync_i is sampled high after it was sampled low on the previous one. That transition drives bit 7 (MSB) of the word. Bits 6 down to 0 follow on the next seven rising transitions.
- R3: dout_oe_o is high for exactly those eight bit times. It falls on the ninth rising transition, unless a repeat timeslot follows at once in variable mode.
- R4: ts_n_o is low exactly while dout_oe_o is high in fixed mode (var_mode_i = 0). It stays high in variable mode.
- R5: In fixed mode, a signalling frame is one where fsync_i is still high at the second rising transition. In such a frame, with alaw_i = 0, the eighth bit sent is sig_i, sampled at the transition that drives that bit. With alaw_i = 1, or in a single-width frame, the eighth bit is the word's LSB.
- R6: var_mode_i = 1 makes dclk_i the bit clock and mclk_i has no effect. While fsync_i stays high at each ninth transition, the same word is sent again with dout_oe_o held high, and no signalling substitution is made.
- R7: The word sent in a frame is the last word_i captured with word_vld_i before that frame started. A load during a frame does not change the bits of that frame.
- R8: While chan_en_i is 0, dout_oe_o is 0 and ts_n_o is 1 within the same clock cycle. A frame in progress is abandoned and does not resume when the channel is enabled again.
- R9: dout_o changes only on the fabric-clock edge that detects a rising bit-clock transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mclk_i | input | 1 | Master clock level, the bit clock in fixed mode |
| dclk_i | input | 1 | Data clock level, the bit clock in variable mode |
| fsync_i | input | 1 | Frame sync / timeslot enable |
| word_i | input | 8 | Parallel PCM word from the encoder |
| word_vld_i | input | 1 | Load strobe for word_i |
| sig_i | input | 1 | Signalling bit |
| alaw_i | input | 1 | 1 selects A-law (no signalling substitution) |
| var_mode_i | input | 1 | 0 fixed-rate, 1 variable-rate |
| chan_en_i | input | 1 | Channel enable |
| dout_o | output | 1 | Serial PCM data |
| dout_oe_o | output | 1 | Output enable for the data pad |
| ts_n_o | output | 1 | Active-low timeslot strobe |

## Verification
Fixed-mode frames are run with single-width and double-width sync pulses, with sig_i set opposite to the word's LSB. This separates correct substitution from plain LSB transmission, and A-law from mu-law. Words with different bit patterns expose bit-order and off-by-one errors in the bit index. A load placed in the middle of a frame tells a frame-boundary latch apart from a transparent one. Variable-mode runs pulse the master clock with sync high to show it is ignored. They then hold sync high across two timeslots to check the repeat with no gap in the enable, and disabling the channel mid-frame checks that the frame is abandoned and not resumed.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int unsigned PCM_WORD_W = 8;
  typedef enum logic {
    RATE_FIXED = 1'b0,
    RATE_VAR   = 1'b1
  } rate_mode_e;
endpackage

// File: rtl/pcm_tx_bclk.sv
module pcm_tx_bclk
  import pcm_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mclk_i,
  input  logic       dclk_i,
  input  rate_mode_e mode_i,
  output logic       rise_o
);
  logic bclk, bclk_q;

  assign bclk = (mode_i == RATE_VAR) ? dclk_i : mclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_q <= 1'b0;
    else         bclk_q <= bclk;
  end

  assign rise_o = bclk & ~bclk_q;
endmodule

// File: rtl/pcm_tx_ctl.sv
module pcm_tx_ctl
  import pcm_tx_pkg::*;
#(
  parameter int unsigned WORD_W = PCM_WORD_W,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fsync_i,
  input  rate_mode_e       mode_i,
  input  logic             en_i,
  output logic             active_o,
  output logic             active_d_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic             sig_frame_d_o,
  output logic             load_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sig_q, sig_d;
  logic             fs_prev_q;
  logic             start, last, rpt, is_var;

  assign is_var = (mode_i == RATE_VAR);
  assign start  = rise_i & en_i & fsync_i & ~fs_prev_q;
  assign last   = active_q & (cnt_q == LAST_IDX);
  assign rpt    = rise_i & en_i & last & is_var & fsync_i;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    sig_d    = sig_q;
    if (!en_i) begin
      active_d = 1'b0;
      cnt_d    = '0;
      sig_d    = 1'b0;
    end else if (start) begin
      active_d = 1'b1;
      cnt_d    = '0;
      sig_d    = 1'b0;
    end else if (rpt) begin
      cnt_d = '0;
    end else if (rise_i && active_q) begin
      if (last) begin
        active_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        // sync still high at second edge: double-width pulse
        if (cnt_q == '0 && fsync_i && !is_var) sig_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      cnt_q     <= '0;
      sig_q     <= 1'b0;
      fs_prev_q <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      sig_q    <= sig_d;
      if (rise_i) fs_prev_q <= fsync_i;
    end
  end

  assign active_o      = active_q;
  assign active_d_o    = active_d;
  assign cnt_d_o       = cnt_d;
  assign sig_frame_d_o = sig_d;
  assign load_o        = start;

  // R2
  frame_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> (cnt_q == '0) && $past(rise_i));

  // R3
  word_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && en_i && last && !(is_var && fsync_i) && !start) |=> !active_q);

  // R8
  chan_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !active_q);
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift
  import pcm_tx_pkg::*;
#(
  parameter int unsigned WORD_W = PCM_WORD_W,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic              load_i,
  input  logic              rise_i,
  input  logic              active_d_i,
  input  logic [CNT_W-1:0]  cnt_d_i,
  input  logic              sub_i,
  input  logic              sig_i,
  output logic              dout_o
);
  localparam logic [CNT_W-1:0] MSB_IDX = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] pend_q, word_q, word_sel;
  logic              dout_q;

  assign word_sel = load_i ? pend_q : word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      word_q <= '0;
      dout_q <= 1'b0;
    end else begin
      if (word_vld_i) pend_q <= word_i;
      if (load_i)     word_q <= pend_q;
      if (rise_i && active_d_i)
        dout_q <= sub_i ? sig_i : word_sel[MSB_IDX - cnt_d_i];
    end
  end

  assign dout_o = dout_q;

  // R9
  dout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rise_i) |-> $stable(dout_q));
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
  import pcm_tx_pkg::*;
#(
  parameter int unsigned WORD_W = PCM_WORD_W,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mclk_i,
  input  logic              dclk_i,
  input  logic              fsync_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic              sig_i,
  input  logic              alaw_i,
  input  logic              var_mode_i,
  input  logic              chan_en_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              ts_n_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  rate_mode_e       mode;
  logic             rise, active, active_d, sig_frame_d, load, sub;
  logic [CNT_W-1:0] cnt_d;

  assign mode = var_mode_i ? RATE_VAR : RATE_FIXED;

  pcm_tx_bclk i_bclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mclk_i (mclk_i),
    .dclk_i (dclk_i),
    .mode_i (mode),
    .rise_o (rise)
  );

  pcm_tx_ctl #(.WORD_W(WORD_W)) i_ctl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rise_i        (rise),
    .fsync_i       (fsync_i),
    .mode_i        (mode),
    .en_i          (chan_en_i),
    .active_o      (active),
    .active_d_o    (active_d),
    .cnt_d_o       (cnt_d),
    .sig_frame_d_o (sig_frame_d),
    .load_o        (load)
  );

  assign sub = (cnt_d == LAST_IDX) & sig_frame_d & ~alaw_i & (mode == RATE_FIXED);

  pcm_tx_shift #(.WORD_W(WORD_W)) i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_i     (word_i),
    .word_vld_i (word_vld_i),
    .load_i     (load),
    .rise_i     (rise),
    .active_d_i (active_d),
    .cnt_d_i    (cnt_d),
    .sub_i      (sub),
    .sig_i      (sig_i),
    .dout_o     (dout_o)
  );

  assign dout_oe_o = active & chan_en_i;
  assign ts_n_o    = ~(active & chan_en_i & (mode == RATE_FIXED));

  // R4
  strobe_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ts_n_o |-> dout_oe_o && !var_mode_i);
endmodule

// File: tb/test_pcm_tx_port.sv
module test_pcm_tx_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk = 0, dclk = 0, fsync = 0, word_vld = 0, sig = 0, alaw = 0, var_mode = 0, chan_en = 1;
  logic [7:0] word = '0;
  logic dout, dout_oe, ts_n;
  logic s_d, s_oe, s_ts;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcm_tx_port i_pcm_tx_port (
    .clk_i(clk), .rst_ni(rst_n), .mclk_i(mclk), .dclk_i(dclk), .fsync_i(fsync),
    .word_i(word), .word_vld_i(word_vld), .sig_i(sig), .alaw_i(alaw),
    .var_mode_i(var_mode), .chan_en_i(chan_en),
    .dout_o(dout), .dout_oe_o(dout_oe), .ts_n_o(ts_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic fs, input bit use_d);
    @(negedge clk);
    fsync = fs;
    if (use_d) dclk = 1'b1; else mclk = 1'b1;
    @(posedge clk); #1;
    s_d = dout; s_oe = dout_oe; s_ts = ts_n;
    @(negedge clk);
    mclk = 1'b0; dclk = 1'b0;
  endtask

  task automatic load(input logic [7:0] w);
    @(negedge clk);
    word = w; word_vld = 1'b1;
    @(negedge clk);
    word_vld = 1'b0;
  endtask

  task automatic idle(input int n, input bit use_d);
    for (int i = 0; i < n; i++) pulse(1'b0, use_d);
  endtask

  // fixed-mode frame; wide = number of bit times sync stays high
  task automatic frame_fixed(input logic [7:0] w, input int wide, input logic sv,
                             input bit exp_sub, input string tag);
    sig = sv;
    for (int i = 0; i < 8; i++) begin
      pulse(i < wide, 1'b0);
      chk({tag, " R2 bit"}, s_d, (i == 7 && exp_sub) ? sv : w[7-i]);
      chk({tag, " R3 oe"}, s_oe, 1'b1);
      chk({tag, " R4 ts"}, s_ts, 1'b0);
    end
    pulse(1'b0, 1'b0);
    chk({tag, " R3 oe off"}, s_oe, 1'b0);
    chk({tag, " R4 ts off"}, s_ts, 1'b1);
    idle(2, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 oe", dout_oe, 1'b0);
    chk("R1 ts", ts_n, 1'b1);
  endtask

  task automatic t_fixed_normal;
    load(8'hA5);
    idle(2, 1'b0);
    frame_fixed(8'hA5, 1, 1'b0, 1'b0, "normal_a5");
    load(8'h3C);
    frame_fixed(8'h3C, 1, 1'b1, 1'b0, "normal_3c R5");
  endtask

  task automatic t_fixed_sig;
    alaw = 1'b0;
    load(8'h81);
    frame_fixed(8'h81, 2, 1'b0, 1'b1, "R5 sig0");
    load(8'h7E);
    frame_fixed(8'h7E, 2, 1'b1, 1'b1, "R5 sig1");
    // sig_i moving after the eighth edge must not alter dout (R9)
    load(8'h7E);
    sig = 1'b1;
    for (int i = 0; i < 8; i++) pulse(i < 2, 1'b0);
    chk("R5 eighth bit", s_d, 1'b1);
    @(negedge clk); sig = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 hold", dout, 1'b1);
    pulse(1'b0, 1'b0);
    idle(2, 1'b0);
  endtask

  task automatic t_alaw;
    alaw = 1'b1;
    load(8'h55);
    frame_fixed(8'h55, 2, 1'b0, 1'b0, "R5 alaw");
    alaw = 1'b0;
  endtask

  task automatic t_word_latch;
    load(8'hF0);
    load(8'h0F);
    load(8'hC3);
    sig = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i == 3) load(8'h99);
      pulse(i < 1, 1'b0);
      chk("R7 mid-frame load", s_d, 8'hC3 >> (7 - i) & 1);
    end
    pulse(1'b0, 1'b0);
    idle(2, 1'b0);
    frame_fixed(8'h99, 1, 1'b0, 1'b0, "R7 next frame");
  endtask

  task automatic t_var;
    @(negedge clk); var_mode = 1'b1;
    // master clock pulses must be ignored
    for (int i = 0; i < 4; i++) begin
      pulse(1'b1, 1'b0);
      chk("R6 mclk ignored", s_oe, 1'b0);
    end
    load(8'hB6);
    sig = 1'b1;
    for (int i = 0; i < 16; i++) begin
      pulse(1'b1, 1'b1);
      chk("R6 var bit", s_d, 8'hB6 >> (7 - (i % 8)) & 1);
      chk("R6 var oe", s_oe, 1'b1);
      chk("R4 var ts", s_ts, 1'b1);
    end
    pulse(1'b0, 1'b1);
    chk("R6 var oe off", s_oe, 1'b0);
    idle(2, 1'b1);
    @(negedge clk); var_mode = 1'b0; sig = 1'b0;
  endtask

  task automatic t_disable;
    load(8'hE7);
    @(negedge clk); chan_en = 1'b0;
    #1;
    chk("R8 oe off", dout_oe, 1'b0);
    for (int i = 0; i < 9; i++) begin
      pulse(i < 1, 1'b0);
      chk("R8 no frame oe", s_oe, 1'b0);
      chk("R8 no frame ts", s_ts, 1'b1);
    end
    @(negedge clk); chan_en = 1'b1;
    idle(2, 1'b0);
    for (int i = 0; i < 3; i++) pulse(i < 1, 1'b0);
    chk("R8 pre-drop oe", s_oe, 1'b1);
    @(negedge clk); chan_en = 1'b0;
    #1;
    chk("R8 drop oe", dout_oe, 1'b0);
    chk("R8 drop ts", ts_n, 1'b1);
    @(negedge clk); chan_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      pulse(1'b0, 1'b0);
      chk("R8 no resume", s_oe, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_fixed_normal;
    t_fixed_sig;
    t_alaw;
    t_word_latch;
    t_var;
    t_disable;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule